// File: doc/BRIEF.md
# Co-group merge join matcher

This block performs the matching step of a sort-merge equi-join on data that has already been grouped by key. Each of its two inputs carries one record per distinct key of one table. A record holds the key and the first and last row index of the rows that share that key. Keys are unsigned and strictly ascending within each input. The block walks both inputs in merged key order and compares only the two head records. The smaller head is consumed and dropped. When the heads are equal, both are consumed and one join tuple is produced. The tuple holds the two index ranges and the shared key.

Expanding the tuples into actual row pairs happens downstream. Each input uses a valid/ready handshake and a last flag that marks its final record. Every job must carry at least one record per input. Once both last records have been consumed, the block is ready for the next job with no extra control.

Top module: `cgj_matcher`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `o_valid` is low.
- R2: While neither input has finished and both heads are valid, the input whose head key is strictly smaller is consumed alone (its ready high, the other ready low), and no tuple results from it.
- R3: When both heads are valid with equal keys, both are consumed in the same cycle. In the next cycle `o_valid` is high with `o_a_start`/`o_a_end` taken from the input A record, `o_b_start`/`o_b_end` from the input B record, and `o_key` equal to the key.
- R4: While `o_valid` is high and `o_ready` is low, all output fields stay unchanged and both input readies are low.
- R5: After the record flagged last on one input has been consumed, every remaining record of the other input is accepted whenever no tuple is stalled, and none of them produces a tuple.
- R6: After both last records have been consumed, a new job on both inputs is matched from scratch, and the number of tuples per job equals the number of keys common to both inputs.
- R7: While neither input has finished, neither ready is raised unless the opposite input presents a valid head.
- R8: Keys compare as unsigned numbers, so a key with its top bit set orders above every key with its top bit clear.
- R9: With `o_ready` held high and matching heads present every cycle, one tuple is delivered per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_valid | input | 1 | Input A record present |
| a_ready | output | 1 | Input A record accepted this cycle when valid |
| a_start | input | IDX_W | First row index of the input A group |
| a_end | input | IDX_W | Last row index of the input A group |
| a_key | input | KEY_W | Key of the input A group |
| a_last | input | 1 | Final record of input A for this job |
| b_valid | input | 1 | Input B record present |
| b_ready | output | 1 | Input B record accepted this cycle when valid |
| b_start | input | IDX_W | First row index of the input B group |
| b_end | input | IDX_W | Last row index of the input B group |
| b_key | input | KEY_W | Key of the input B group |
| b_last | input | 1 | Final record of input B for this job |
| o_valid | output | 1 | Join tuple present |
| o_ready | input | 1 | Downstream accepts the tuple |
| o_a_start | output | IDX_W | Input A range start of the match |
| o_a_end | output | IDX_W | Input A range end of the match |
| o_b_start | output | IDX_W | Input B range start of the match |
| o_b_end | output | IDX_W | Input B range end of the match |
| o_key | output | KEY_W | Matched key |

## Verification
The bench targets several corner cases, each with a typical failure. A stalled tuple under random back-pressure tests that new matches do not overwrite the pending one and are not lost. Jobs where one input ends early test that the survivor is drained; a faulty design would hang or emit stray tuples. Back-to-back jobs test that finish flags clear exactly once, since a design that missed this would refuse the second job. Keys with the top bit set would be misordered by a signed compare.

// File: rtl/cgj_pkg.sv
// Shared definitions for the co-group merge join matcher.
package cgj_pkg;
    // Ordering of the input A head key against the input B head key.
    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2
    } ord_e;
endpackage

// File: rtl/cgj_key_cmp.sv
// Unsigned key comparator.
// Reports how the input A head key orders against the input B head key.
// Assumes both keys are unsigned and of equal width.
module cgj_key_cmp
    import cgj_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    output ord_e             ord
);
    // Three-way unsigned comparison.
    always_comb begin
        if (key_a < key_b)       ord = ORD_LT;
        else if (key_a == key_b) ord = ORD_EQ;
        else                     ord = ORD_GT;
    end
endmodule

// File: rtl/cgj_phase.sv
// Per-input end-of-job tracker.
// Remembers which input has already delivered its last record. When both
// inputs are finished it clears both flags so the next job starts clean.
// Assumes each input's last record is consumed exactly once per job.
module cgj_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic a_fire,
    input  logic a_last,
    input  logic b_fire,
    input  logic b_last,
    output logic a_over,
    output logic b_over
);
    logic a_nx, b_nx;

    // Finish state each input would reach after this cycle.
    always_comb begin
        a_nx = a_over | (a_fire & a_last);
        b_nx = b_over | (b_fire & b_last);
    end

    // Record finished inputs; release both once the job is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_over <= 1'b0;
            b_over <= 1'b0;
        end else if (a_nx && b_nx) begin
            a_over <= 1'b0;
            b_over <= 1'b0;
        end else begin
            a_over <= a_nx;
            b_over <= b_nx;
        end
    end

    // R6
    job_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_over && b_fire && b_last) |=> (!a_over && !b_over));
endmodule

// File: rtl/cgj_out_reg.sv
// Output holding register for join tuples.
// Loads a tuple when told to, keeps it until downstream takes it, and
// reports whether a new tuple could be accepted this cycle.
// Assumes load is only raised while free is high.
module cgj_out_reg #(
    parameter int IDX_W = 16,
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] in_a_start,
    input  logic [IDX_W-1:0] in_a_end,
    input  logic [IDX_W-1:0] in_b_start,
    input  logic [IDX_W-1:0] in_b_end,
    input  logic [KEY_W-1:0] in_key,
    output logic             free,
    output logic             o_valid,
    input  logic             o_ready,
    output logic [IDX_W-1:0] o_a_start,
    output logic [IDX_W-1:0] o_a_end,
    output logic [IDX_W-1:0] o_b_start,
    output logic [IDX_W-1:0] o_b_end,
    output logic [KEY_W-1:0] o_key
);
    // Register may take a new tuple when empty or being emptied now.
    always_comb free = !o_valid || o_ready;

    // Valid flag: set on load, cleared when downstream takes the tuple.
    always_ff @(posedge clk) begin
        if (!rst_n)          o_valid <= 1'b0;
        else if (load)       o_valid <= 1'b1;
        else if (o_ready)    o_valid <= 1'b0;
    end

    // Payload capture on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_a_start <= '0;
            o_a_end   <= '0;
            o_b_start <= '0;
            o_b_end   <= '0;
            o_key     <= '0;
        end else if (load) begin
            o_a_start <= in_a_start;
            o_a_end   <= in_a_end;
            o_b_start <= in_b_start;
            o_b_end   <= in_b_end;
            o_key     <= in_key;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !o_valid);
    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_a_start) && $stable(o_a_end)
                                   && $stable(o_b_start) && $stable(o_b_end) && $stable(o_key)));
endmodule

// File: rtl/cgj_matcher.sv
// Co-group merge join matcher (top).
// Walks two key-ascending streams of grouped records in merged key order.
// The smaller head is dropped, equal heads are paired into one join tuple.
// Once one stream has ended, the other is drained without output.
// Assumes keys are unique and ascending within each stream, and that every
// job supplies at least one record per stream, the final one flagged last.
module cgj_matcher
    import cgj_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_valid,
    output logic             a_ready,
    input  logic [IDX_W-1:0] a_start,
    input  logic [IDX_W-1:0] a_end,
    input  logic [KEY_W-1:0] a_key,
    input  logic             a_last,
    input  logic             b_valid,
    output logic             b_ready,
    input  logic [IDX_W-1:0] b_start,
    input  logic [IDX_W-1:0] b_end,
    input  logic [KEY_W-1:0] b_key,
    input  logic             b_last,
    output logic             o_valid,
    input  logic             o_ready,
    output logic [IDX_W-1:0] o_a_start,
    output logic [IDX_W-1:0] o_a_end,
    output logic [IDX_W-1:0] o_b_start,
    output logic [IDX_W-1:0] o_b_end,
    output logic [KEY_W-1:0] o_key
);
    ord_e ord;
    logic free, a_over, b_over, a_fire, b_fire, pair;

    cgj_key_cmp #(.KEY_W(KEY_W)) u_cmp (
        .key_a (a_key),
        .key_b (b_key),
        .ord   (ord)
    );

    cgj_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_fire (a_fire),
        .a_last (a_last),
        .b_fire (b_fire),
        .b_last (b_last),
        .a_over (a_over),
        .b_over (b_over)
    );

    // Accept a head when it is not larger than the other head, or the other stream ended.
    always_comb begin
        a_ready = free && !a_over && (b_over || (b_valid && ord != ORD_GT));
        b_ready = free && !b_over && (a_over || (a_valid && ord != ORD_LT));
        a_fire  = a_valid && a_ready;
        b_fire  = b_valid && b_ready;
        pair    = a_fire && b_fire;
    end

    cgj_out_reg #(.IDX_W(IDX_W), .KEY_W(KEY_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pair),
        .in_a_start (a_start),
        .in_a_end   (a_end),
        .in_b_start (b_start),
        .in_b_end   (b_end),
        .in_key     (a_key),
        .free       (free),
        .o_valid    (o_valid),
        .o_ready    (o_ready),
        .o_a_start  (o_a_start),
        .o_a_end    (o_a_end),
        .o_b_start  (o_b_start),
        .o_b_end    (o_b_end),
        .o_key      (o_key)
    );

    // R4
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |-> (!a_ready && !b_ready));
    // R3
    pair_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fire && b_fire) |=> (o_valid && o_key == $past(b_key)
            && o_a_start == $past(a_start) && o_a_end == $past(a_end)
            && o_b_start == $past(b_start) && o_b_end == $past(b_end)));
    // R2
    lone_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fire && !b_fire && b_valid && !b_over) |-> (a_key < b_key));
    // R5
    drain_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fire ^ b_fire) |=> !o_valid);
    // R7
    wait_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_over && !b_over && !b_valid) |-> !a_ready);
endmodule

// File: tb/tb_cgj_matcher.sv
// Self-checking bench: a behavioural per-cycle reference compared on every clock.
module tb_cgj_matcher;
    localparam int IW = 16;
    localparam int KW = 16;

    typedef struct {
        logic [KW-1:0] key;
        logic [IW-1:0] s;
        logic [IW-1:0] e;
        bit            last;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 0, b_valid = 0, a_last = 0, b_last = 0, o_ready = 0;
    logic [IW-1:0] a_start = 0, a_end = 0, b_start = 0, b_end = 0;
    logic [KW-1:0] a_key = 0, b_key = 0;
    logic a_ready, b_ready, o_valid;
    logic [IW-1:0] o_a_start, o_a_end, o_b_start, o_b_end;
    logic [KW-1:0] o_key;

    always #4 clk = ~clk;

    cgj_matcher #(.IDX_W(IW), .KEY_W(KW)) dut (.*);

    int tests = 0, fails = 0, cyc = 0, seen = 0;
    rec_t qa[$], qb[$];
    bit m_ov = 0, m_aend = 0, m_bend = 0, fa = 0, fb = 0;
    logic [79:0] m_t = '0;

    task automatic chk(bit ok, string req, string what, logic [79:0] act, logic [79:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Builds one stream of n groups with ascending keys.
    task automatic gen(bit to_a, int n, int base, int step);
        int k = base;
        int ix = 0;
        for (int i = 0; i < n; i++) begin
            rec_t r;
            int len = $urandom_range(0, 3);
            k += $urandom_range(1, step);
            r.key = k[KW-1:0]; r.s = ix[IW-1:0]; r.e = IW'(ix + len);
            r.last = (i == n - 1);
            ix += len + 1;
            if (to_a) qa.push_back(r); else qb.push_back(r);
        end
    endtask

    // Runs the queued job; pa/pb/pr are percent chances of valid/ready.
    task automatic run_job(int pa, int pb, int pr, string req);
        int want = 0;
        int got0 = seen;
        bit can, ea, eb;
        foreach (qa[i]) foreach (qb[j]) if (qa[i].key == qb[j].key) want++;
        fa = 0; fb = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            a_valid = (qa.size() > 0) && ((a_valid && !fa) || ($urandom_range(1, 100) <= pa));
            b_valid = (qb.size() > 0) && ((b_valid && !fb) || ($urandom_range(1, 100) <= pb));
            if (qa.size() > 0) begin a_key = qa[0].key; a_start = qa[0].s; a_end = qa[0].e; a_last = qa[0].last; end
            if (qb.size() > 0) begin b_key = qb[0].key; b_start = qb[0].s; b_end = qb[0].e; b_last = qb[0].last; end
            o_ready = ($urandom_range(1, 100) <= pr);
            #2;
            can = !m_ov || o_ready;
            ea = can && !m_aend && (m_bend || (b_valid && qa[0].key <= qb[0].key));
            eb = can && !m_bend && (m_aend || (a_valid && qb[0].key <= qa[0].key));
            chk(a_ready == ea, (m_aend || m_bend) ? "R5" : "R2", "a_ready", 80'(a_ready), 80'(ea));
            chk(b_ready == eb, (m_aend || m_bend) ? "R5" : "R7", "b_ready", 80'(b_ready), 80'(eb));
            chk(o_valid == m_ov, "R9", "o_valid", 80'(o_valid), 80'(m_ov));
            if (m_ov)
                chk({o_a_start, o_a_end, o_b_start, o_b_end, o_key} == m_t, o_ready ? "R3" : "R4",
                    "tuple", {o_a_start, o_a_end, o_b_start, o_b_end, o_key}, m_t);
            fa = a_valid && ea;
            fb = b_valid && eb;
            if (m_ov && o_ready) begin m_ov = 0; seen++; end
            if (fa && fb) begin
                m_ov = 1;
                m_t = {qa[0].s, qa[0].e, qb[0].s, qb[0].e, qa[0].key};
            end
            begin
                bit na = m_aend || (fa && qa[0].last);
                bit nb = m_bend || (fb && qb[0].last);
                if (na && nb) begin m_aend = 0; m_bend = 0; end
                else begin m_aend = na; m_bend = nb; end
            end
            if (fa) void'(qa.pop_front());
            if (fb) void'(qb.pop_front());
            if (qa.size() == 0 && qb.size() == 0 && !m_ov) break;
        end
        chk(qa.size() == 0 && qb.size() == 0, "R5", "records left", 80'(qa.size() + qb.size()), 80'(0));
        chk(seen - got0 == want, req, "tuple count", 80'(seen - got0), 80'(want));
        @(negedge clk); a_valid = 0; b_valid = 0; fa = 0; fb = 0;
    endtask

    function automatic rec_t mk(int k, int s, int e, bit l);
        rec_t r;
        r.key = k[KW-1:0]; r.s = s[IW-1:0]; r.e = e[IW-1:0]; r.last = l;
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(o_valid == 0, "R1", "o_valid in reset", 80'(o_valid), 80'(0));
        rst_n = 1;
        @(negedge clk);
        chk(o_valid == 0, "R1", "o_valid after reset", 80'(o_valid), 80'(0));
        a_valid = 1; b_valid = 0; #1;
        chk(a_ready == 0, "R7", "a_ready without B head", 80'(a_ready), 80'(0));
        a_valid = 0;

        // Small grouped example: keys 2 and 3 match.
        qa = '{mk(2, 0, 1, 0), mk(3, 2, 4, 0), mk(11, 5, 5, 1)};
        qb = '{mk(2, 0, 1, 0), mk(3, 2, 2, 0), mk(5, 3, 3, 0), mk(6, 4, 4, 1)};
        run_job(100, 100, 100, "R3");

        // One stream ends at once; other drained silently.
        qa = '{mk(1, 0, 0, 1)};
        qb = '{mk(10, 0, 0, 0), mk(11, 1, 1, 0), mk(12, 2, 2, 0), mk(13, 3, 3, 1)};
        run_job(100, 100, 100, "R5");

        // Top-bit keys order above small keys.
        qa = '{mk(5, 0, 0, 0), mk(32768, 1, 2, 1)};
        qb = '{mk(32767, 0, 0, 0), mk(32768, 1, 1, 1)};
        run_job(100, 100, 100, "R8");

        // All keys equal in lockstep: full throughput.
        for (int i = 0; i < 6; i++) begin
            qa.push_back(mk(i * 3 + 1, i, i, i == 5));
            qb.push_back(mk(i * 3 + 1, i * 2, i * 2 + 1, i == 5));
        end
        run_job(100, 100, 100, "R9");

        // Random jobs, back to back, with gaps and back-pressure.
        for (int j = 0; j < 40; j++) begin
            gen(1, $urandom_range(1, 30), 0, 4);
            gen(0, $urandom_range(1, 30), 0, 4);
            run_job($urandom_range(30, 100), $urandom_range(30, 100), $urandom_range(20, 100), "R6");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule